// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control heart of a microcoded processor. It holds a control address register that points into an on-chip control store. Each clock edge it latches both the new micro-address and the microword found there. The latched word is horizontal. Its control field drives the datapath directly, one bit per control line, and several lines can be active at once. The remaining fields tell the sequence logic how to choose the following micro-address.

The next micro-address is chosen in one of three ways. It can be the current address plus one. It can be a jump to the word's target field, taken when a selected ALU flag is true and falling through to plus one otherwise. It can be a dispatch to the routine for the machine opcode held in the instruction register. Each opcode owns a block of four microwords. The control store is a constant image built into the RTL. A fetch routine sits at address 0, which is where reset starts.

Top module: `mseq_top`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `uaddr_o` becomes 0 and `ctrl_o` becomes 12'h001, the control field of word 0.
- R2: One microword completes per cycle. The address and the word change together at each rising edge, and `ctrl_o` is always the full control field of the word at `uaddr_o`, with several bits set at once where that word has them.
- R3: A word of kind increment moves `uaddr_o` to its own address plus one, modulo the store depth, at the next edge.
- R4: A word of kind jump whose condition holds loads its target field into `uaddr_o` at the next edge.
- R5: A jump whose condition does not hold falls through to its own address plus one. Condition select codes 5, 6 and 7 never hold.
- R6: Condition select codes: 0 is always, 1 is zero (`flags_i[0]`), 2 is carry (`flags_i[1]`), 3 is sign (`flags_i[2]`), 4 is overflow (`flags_i[3]`).
- R7: A word of kind dispatch loads `{opcode_i, 2'b00}` into `uaddr_o` at the next edge. Opcode 0 therefore lands back on the fetch routine.
- R8: Store image. Words 0, 1 and 2 have control fields 12'h001, 12'h002 and 12'h004; words 0 and 1 increment, and word 2 dispatches. For an opcode k of 1 or more, the word at address a = 4k+j has control field {2'b10, j[1:0], 2'b00, a[5:0]}. Word 4k increments. Word 4k+1 jumps to 0 under select code k mod 8. Word 4k+2 jumps to 0 always.
- R9: `flags_i` matters only at the edge that leaves a jump word, and `opcode_i` only at the edge that leaves a dispatch word. Changes at other times have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode_i | input | OPC_W (4) | Machine opcode from the instruction register |
| flags_i | input | 4 | ALU flags: bit 0 zero, bit 1 carry, bit 2 sign, bit 3 overflow |
| ctrl_o | output | CTRL_W (12) | Control signal bus, the control field of the current microword |
| uaddr_o | output | OPC_W+2 (6) | Current micro-address |

## Verification
Each opcode is run through a full fetch, dispatch and routine trace. The flag vector either sets only the selected flag or sets every flag except that one. This separates a correct condition decode from one that tests the wrong bit or inverts it. Opcodes whose select code is "never" are run with all flags set, and an "always" opcode is run with all flags clear, so a mis-decoded constant condition shows up. Opcode 0 and a reset in the middle of a routine check the two ways back to address 0. Flags and opcode are also changed at cycles where they must be ignored, which shows when each input is sampled.

// File: rtl/mseq_pkg.sv
// Package mseq_pkg
// Shared encodings for the microprogram sequencer: the kinds of next-address
// selection, the condition select codes, and the ALU flag bit positions.
// Assumes the microword packs {control, kind, condition, target} from MSB to LSB.
package mseq_pkg;

    typedef enum logic [1:0] {
        NX_INC  = 2'd0,
        NX_JUMP = 2'd1,
        NX_DISP = 2'd2,
        NX_RSVD = 2'd3
    } nxt_kind_e;

    localparam logic [2:0] CC_ALWAYS = 3'd0;
    localparam logic [2:0] CC_ZERO   = 3'd1;
    localparam logic [2:0] CC_CARRY  = 3'd2;
    localparam logic [2:0] CC_SIGN   = 3'd3;
    localparam logic [2:0] CC_OVF    = 3'd4;

    localparam int FLG_Z = 0;
    localparam int FLG_C = 1;
    localparam int FLG_N = 2;
    localparam int FLG_V = 3;

    localparam int KIND_W = 2;
    localparam int COND_W = 3;

endpackage

// File: rtl/mseq_store.sv
// Module mseq_store
// Constant control store. Each word is computed by a function of its address,
// so no literal table is written out. The read is combinational; the caller
// registers the word. Assumes ADDR_W == OPC_W + 2 (four words per opcode).
module mseq_store
    import mseq_pkg::*;
#(
    parameter int CTRL_W = 12,
    parameter int OPC_W  = 4,
    parameter int ADDR_W = OPC_W + 2
) (
    input  logic [ADDR_W-1:0]                       rd_addr,
    output logic [CTRL_W+KIND_W+COND_W+ADDR_W-1:0]  rd_word
);
    localparam int WORD_W = CTRL_W + KIND_W + COND_W + ADDR_W;

    // Builds the microword for one address of the fixed microprogram.
    function automatic logic [WORD_W-1:0] image(input logic [ADDR_W-1:0] a);
        logic [CTRL_W-1:0] c;
        nxt_kind_e         k;
        logic [2:0]        cc;
        logic [ADDR_W-1:0] t;
        logic [OPC_W-1:0]  op;
        logic [1:0]        off;
        op  = a[ADDR_W-1:2];
        off = a[1:0];
        t   = '0;
        cc  = CC_ALWAYS;
        if (op == '0) begin
            case (off)
                2'd0:    begin c = CTRL_W'(1); k = NX_INC;  end
                2'd1:    begin c = CTRL_W'(2); k = NX_INC;  end
                2'd2:    begin c = CTRL_W'(4); k = NX_DISP; end
                default: begin c = '0;         k = NX_JUMP; end
            endcase
        end else begin
            c = CTRL_W'({2'b10, off, 2'b00, a});
            case (off)
                2'd0:    k = NX_INC;
                2'd1:    begin k = NX_JUMP; cc = 3'(op); end
                2'd2:    k = NX_JUMP;
                default: k = NX_INC;
            endcase
        end
        return {c, k, cc, t};
    endfunction

    // Reads the addressed word from the constant image.
    always_comb begin
        rd_word = image(rd_addr);
    end

endmodule

// File: rtl/mseq_next.sv
// Module mseq_next
// Sequence logic: picks the next micro-address from the current word's kind,
// condition select and target, the ALU flags and the machine opcode.
// Assumes ADDR_W == OPC_W + 2; reserved kind behaves as increment.
module mseq_next
    import mseq_pkg::*;
#(
    parameter int OPC_W  = 4,
    parameter int ADDR_W = OPC_W + 2
) (
    input  logic [ADDR_W-1:0] car_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic [COND_W-1:0] cond_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic [3:0]        flags_i,
    input  logic [OPC_W-1:0]  opcode_i,
    output logic [ADDR_W-1:0] nxt_o
);
    logic              cond_hit;
    logic [ADDR_W-1:0] seq_addr;

    // Evaluates the selected condition against the ALU flags.
    always_comb begin
        case (cond_i)
            CC_ALWAYS: cond_hit = 1'b1;
            CC_ZERO:   cond_hit = flags_i[FLG_Z];
            CC_CARRY:  cond_hit = flags_i[FLG_C];
            CC_SIGN:   cond_hit = flags_i[FLG_N];
            CC_OVF:    cond_hit = flags_i[FLG_V];
            default:   cond_hit = 1'b0;
        endcase
    end

    // Chooses between sequential, jump and dispatch addresses.
    always_comb begin
        seq_addr = car_i + ADDR_W'(1);
        case (nxt_kind_e'(kind_i))
            NX_JUMP: nxt_o = cond_hit ? target_i : seq_addr;
            NX_DISP: nxt_o = {opcode_i, 2'b00};
            default: nxt_o = seq_addr;
        endcase
    end

endmodule

// File: rtl/mseq_top.sv
// Module mseq_top
// Microprogrammed control sequencer. The control address register and the
// control buffer register load together each edge, so the buffered word is
// always the one at the current address. Reset forces address 0 and word 0.
// Assumes flags_i and opcode_i are stable around the rising edge.
module mseq_top
    import mseq_pkg::*;
#(
    parameter int CTRL_W = 12,
    parameter int OPC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic [3:0]        flags_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [OPC_W+1:0]  uaddr_o
);
    localparam int ADDR_W = OPC_W + 2;
    localparam int WORD_W = CTRL_W + KIND_W + COND_W + ADDR_W;

    logic [ADDR_W-1:0] car_q;
    logic [ADDR_W-1:0] nxt_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] cbr_q;
    logic [WORD_W-1:0] rd_word;
    logic [KIND_W-1:0] cbr_kind;
    logic [COND_W-1:0] cbr_cond;
    logic [ADDR_W-1:0] cbr_target;

    // Splits the buffered microword into its fields.
    assign {ctrl_o, cbr_kind, cbr_cond, cbr_target} = cbr_q;
    assign uaddr_o = car_q;

    mseq_next #(.OPC_W(OPC_W), .ADDR_W(ADDR_W)) next_i (
        .car_i    (car_q),
        .kind_i   (cbr_kind),
        .cond_i   (cbr_cond),
        .target_i (cbr_target),
        .flags_i  (flags_i),
        .opcode_i (opcode_i),
        .nxt_o    (nxt_addr)
    );

    // Reset steers the store read to the fetch entry point.
    assign rd_addr = rst_n ? nxt_addr : '0;

    mseq_store #(.CTRL_W(CTRL_W), .OPC_W(OPC_W), .ADDR_W(ADDR_W)) store_i (
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    // Latches the new micro-address and its word on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            car_q <= '0;
            cbr_q <= rd_word;
        end else begin
            car_q <= nxt_addr;
            cbr_q <= rd_word;
        end
    end

endmodule

// File: rtl/mseq_chk.sv
// Module mseq_chk
// Property checker for the sequencer, bound into every mseq_top instance.
// Watches the micro-address against the buffered word's sequencing fields.
module mseq_chk
    import mseq_pkg::*;
#(
    parameter int OPC_W  = 4,
    parameter int ADDR_W = OPC_W + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OPC_W-1:0]  opcode_i,
    input logic [3:0]        flags_i,
    input logic [ADDR_W-1:0] uaddr_o,
    input logic [KIND_W-1:0] cbr_kind,
    input logic [COND_W-1:0] cbr_cond,
    input logic [ADDR_W-1:0] cbr_target
);
    logic is_jump;
    assign is_jump = (cbr_kind == NX_JUMP);

    assert_reset_addr_R1: assert property (@(posedge clk)
        !rst_n |=> (uaddr_o == '0));

    assert_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cbr_kind == NX_INC) |=> (uaddr_o == $past(uaddr_o) + ADDR_W'(1)));

    assert_jump_always_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_jump && cbr_cond == CC_ALWAYS) |=> (uaddr_o == $past(cbr_target)));

    assert_zero_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_jump && cbr_cond == CC_ZERO && !flags_i[FLG_Z])
            |=> (uaddr_o == $past(uaddr_o) + ADDR_W'(1)));

    assert_never_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_jump && cbr_cond > CC_OVF) |=> (uaddr_o == $past(uaddr_o) + ADDR_W'(1)));

    assert_carry_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_jump && cbr_cond == CC_CARRY && flags_i[FLG_C]) |=> (uaddr_o == $past(cbr_target)));

    assert_dispatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cbr_kind == NX_DISP) |=> (uaddr_o == {$past(opcode_i), 2'b00}));

endmodule

bind mseq_top mseq_chk #(.OPC_W(OPC_W), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .opcode_i   (opcode_i),
    .flags_i    (flags_i),
    .uaddr_o    (uaddr_o),
    .cbr_kind   (cbr_kind),
    .cbr_cond   (cbr_cond),
    .cbr_target (cbr_target)
);

// File: tb/mseq_top_tb_top.sv
`timescale 1ns/1ps
// Bench for mseq_top: a vector table of opcode, flags and expected branch
// outcome walked through full instruction traces, then directed tests.
module mseq_top_tb_top;
    localparam int CTRL_W = 12;
    localparam int OPC_W  = 4;
    localparam int ADDR_W = OPC_W + 2;
    localparam int NVEC   = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [OPC_W-1:0]  opcode = '0;
    logic [3:0]        flags = '0;
    logic [CTRL_W-1:0] ctrl;
    logic [ADDR_W-1:0] uaddr;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // {opcode, flags(V,N,C,Z), branch taken}
    localparam logic [8:0] VEC [NVEC] = '{
        {4'd1,  4'b0001, 1'b1},
        {4'd1,  4'b1110, 1'b0},
        {4'd2,  4'b0010, 1'b1},
        {4'd2,  4'b1101, 1'b0},
        {4'd3,  4'b0100, 1'b1},
        {4'd3,  4'b1011, 1'b0},
        {4'd4,  4'b1000, 1'b1},
        {4'd4,  4'b0111, 1'b0},
        {4'd5,  4'b1111, 1'b0},
        {4'd8,  4'b0000, 1'b1},
        {4'd15, 4'b1111, 1'b0},
        {4'd9,  4'b0001, 1'b1}
    };

    mseq_top #(.CTRL_W(CTRL_W), .OPC_W(OPC_W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode_i (opcode),
        .flags_i  (flags),
        .ctrl_o   (ctrl),
        .uaddr_o  (uaddr)
    );

    always #5 clk = ~clk;

    // Expected control field of a store word, from R8.
    function automatic logic [CTRL_W-1:0] exp_ctrl(input logic [ADDR_W-1:0] a);
        if (a < 4) begin
            case (a[1:0])
                2'd0:    return 12'h001;
                2'd1:    return 12'h002;
                2'd2:    return 12'h004;
                default: return 12'h000;
            endcase
        end
        return {2'b10, a[1:0], 2'b00, a};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic at_addr(input string req, input logic [ADDR_W-1:0] a);
        check(req, 32'(uaddr), 32'(a));
        check("R2 ctrl", 32'(ctrl), 32'(exp_ctrl(a)));
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Runs fetch, dispatch and routine; starts and ends at address 0.
    task automatic run_instr(input logic [OPC_W-1:0] op, input logic [3:0] fl, input bit tk);
        logic [ADDR_W-1:0] base;
        base   = {op, 2'b00};
        opcode = op;
        flags  = fl;
        at_addr("R8 fetch0", 0);
        step(); at_addr("R3 fetch1", 1);
        step(); at_addr("R3 fetch2", 2);
        step(); at_addr("R7 dispatch", base);
        step(); at_addr("R3 routine inc", base + 1);
        step();
        if (tk) begin
            at_addr("R4 R6 taken", 0);
        end else begin
            at_addr("R5 R6 fallthrough", base + 2);
            step(); at_addr("R4 always to fetch", 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        at_addr("R1 reset", 0);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            run_instr(VEC[i][8:5], VEC[i][4:1], VEC[i][0]);
        end

        // R7: opcode 0 dispatches back to fetch
        opcode = '0;
        at_addr("R7 op0", 0);
        step(); at_addr("R7 op0", 1);
        step(); at_addr("R7 op0", 2);
        step(); at_addr("R7 op0 lands on fetch", 0);

        // R9: flags only sampled at jump edge, opcode only at dispatch edge
        opcode = 4'd1; flags = 4'b0001;
        step(); step(); step();
        at_addr("R9 dispatch", 4);
        flags  = 4'b0000;
        opcode = 4'd3;
        step(); at_addr("R9 late change ignored", 5);
        step(); at_addr("R9 flags at jump edge", 6);
        step(); at_addr("R9 back", 0);

        opcode = 4'd1; flags = 4'b1110;
        step(); step(); step(); step();
        at_addr("R9 at jump word", 5);
        flags = 4'b0001;
        step(); at_addr("R9 late zero taken", 0);

        // R1: reset in the middle of a routine
        opcode = 4'd6; flags = 4'b0000;
        step(); step(); step();
        at_addr("R1 pre", 24);
        rst_n = 1'b0;
        step(); at_addr("R1 mid-run reset", 0);
        step(); at_addr("R1 held", 0);
        rst_n = 1'b1;
        step(); at_addr("R1 restart", 1);

        done = 1'b1;
        summary();
    end
endmodule